// File: doc/BRIEF.md
# Mode-Dependent Oversampling Averager

This block takes a stream of signed raw samples and turns it into a slower stream of averaged samples. It adds up a run of accepted samples and, once the run is long enough, emits their mean together with a one-clock valid strobe. After that the next run starts from an empty sum.

The run length, called the averaging ratio, is not fixed. It is read every cycle from a built-in table indexed by a 2-bit oversampling mode and a 3-bit output-rate code, and it ranges from 2 to 1024. Every ratio is a power of two, so the division is done as an arithmetic right shift.

When either code changes, the partial run is thrown away and averaging restarts under the new ratio. The block therefore never emits a value computed from a mix of two settings.

Top module: `os_averager`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle that follows, `out_valid` is 0 and `out_data` is 0.
- R2: `os_mode` selects the mode: 0 = normal, 1 = low-noise low-power, 2 = high-resolution, 3 = low-power. `rate_code` values 0 to 7 stand for the output rates 800, 400, 200, 100, 50, 12.5, 6.25 and 1.56 Hz.
- R3: The ratio for rate codes 7,6,5,4,3,2,1,0 is: normal 128,32,16,4,4,4,4,2; low-noise low-power 32,8,4,4,4,4,4,2; high-resolution 1024,256,128,32,16,8,4,2; low-power 16,4,2,2,2,2,2,2. Each run uses exactly that many accepted samples.
- R4: The emitted value is the sum of the run divided by the ratio, rounded toward negative infinity.
- R5: `out_valid` goes high for exactly one clock. It does so in the cycle after the clock edge that accepts the last sample of a run.
- R6: A cycle with `in_valid` low adds nothing to the run and does not advance the sample count, whatever `in_sample` holds.
- R7: A clock edge at which `{os_mode, rate_code}` differs from its value at the previous edge discards the partial sum and count. A sample accepted at that same edge is the first sample of the new run. No output is produced from the discarded part.
- R8: A run of 1024 full-scale samples (all -8192 or all +8191) is summed without overflow and gives back that same value.
- R9: `out_data` keeps its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Raw sample present |
| in_sample | input | 14 | Raw sample, two's complement |
| os_mode | input | 2 | Oversampling mode code |
| rate_code | input | 3 | Output rate code |
| out_valid | output | 1 | One-clock strobe marking a new average |
| out_data | output | 14 | Latest average, two's complement |

## Verification
Assertions inside the design check several properties on every cycle:
- The sample count stays below the ratio of the configuration it belongs to.
- The partial sum stays within the bounds that its count allows.
- The strobe never lasts two cycles, and it always follows an accepted sample.
- No strobe follows a code change.
- The output is held between strobes.

Only the bench's scenarios can show the rest:
- that the run length matches the table for each of the 32 mode and rate pairs;
- that the mean rounds down for negative sums;
- that full-scale runs come back exactly;
- that a partial run abandoned by a code change leaves no trace in the next result.

// File: rtl/os_avg_pkg.sv
package os_avg_pkg;

    localparam int OS_MAX_SHIFT = 10;

    typedef enum logic [1:0] {
        OSM_NORMAL = 2'd0,
        OSM_LNLP   = 2'd1,
        OSM_HIRES  = 2'd2,
        OSM_LOWPWR = 2'd3
    } os_mode_e;

    typedef struct packed {
        os_mode_e    mode;
        logic [2:0]  rate;
    } os_cfg_t;

    // log2 of the averaging ratio; rate 0 is the fastest output rate
    function automatic logic [3:0] os_ratio_log2(input os_cfg_t c);
        logic [3:0] s;
        s = 4'd1;
        unique case (c.mode)
            OSM_NORMAL: begin
                case (c.rate)
                    3'd0:    s = 4'd1;
                    3'd5:    s = 4'd4;
                    3'd6:    s = 4'd5;
                    3'd7:    s = 4'd7;
                    default: s = 4'd2;
                endcase
            end
            OSM_LNLP: begin
                case (c.rate)
                    3'd0:    s = 4'd1;
                    3'd6:    s = 4'd3;
                    3'd7:    s = 4'd5;
                    default: s = 4'd2;
                endcase
            end
            OSM_HIRES: begin
                case (c.rate)
                    3'd5:    s = 4'd7;
                    3'd6:    s = 4'd8;
                    3'd7:    s = 4'd10;
                    default: s = 4'({1'b0, c.rate}) + 4'd1;
                endcase
            end
            OSM_LOWPWR: begin
                case (c.rate)
                    3'd6:    s = 4'd2;
                    3'd7:    s = 4'd4;
                    default: s = 4'd1;
                endcase
            end
            default: s = 4'd1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/avg_cfg_track.sv
module avg_cfg_track
    import os_avg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  os_cfg_t  cfg_in,
    output logic     cfg_change,
    output logic [3:0] shift_now,
    output logic [3:0] shift_q
);
    os_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_in;
    end

    always_comb begin
        cfg_change = (cfg_in != cfg_q);
        shift_now  = os_ratio_log2(cfg_in);
        shift_q    = os_ratio_log2(cfg_q);
    end
endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
    parameter int SAMPLE_W  = 14,
    parameter int MAX_SHIFT = 10,
    localparam int ACC_W    = SAMPLE_W + MAX_SHIFT,
    localparam int CNT_W    = MAX_SHIFT + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic                       cfg_change,
    input  logic [3:0]                 shift_now,
    input  logic [3:0]                 shift_q,
    output logic                       done,
    output logic signed [ACC_W-1:0]    sum_full
);
    logic signed [ACC_W-1:0] acc_q, base_acc, ext_sample;
    logic [CNT_W-1:0]        cnt_q, base_cnt, cnt_next, ratio_now;

    always_comb begin
        base_acc   = cfg_change ? '0 : acc_q;
        base_cnt   = cfg_change ? '0 : cnt_q;
        ext_sample = {{MAX_SHIFT{in_sample[SAMPLE_W-1]}}, in_sample};
        sum_full   = base_acc + ext_sample;
        cnt_next   = base_cnt + CNT_W'(1);
        ratio_now  = CNT_W'(1) << shift_now;
        done       = in_valid && (cnt_next == ratio_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (in_valid) begin
            if (done) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= sum_full;
                cnt_q <= cnt_next;
            end
        end else if (cfg_change) begin
            acc_q <= '0;
            cnt_q <= '0;
        end
    end

    // count belongs to the registered configuration and never reaches its ratio
    assert_cnt_below_ratio_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < (CNT_W'(1) << shift_q));

    // partial sum bounded by count times full-scale magnitude
    logic signed [ACC_W+1:0] lo_bound, hi_bound, acc_wide;
    always_comb begin
        acc_wide = (ACC_W+2)'(acc_q);
        hi_bound = (ACC_W+2)'(cnt_q) * (ACC_W+2)'((1 << (SAMPLE_W-1)) - 1);
        lo_bound = -((ACC_W+2)'(cnt_q) * (ACC_W+2)'(1 << (SAMPLE_W-1)));
    end
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_wide <= hi_bound) && (acc_wide >= lo_bound));
endmodule

// File: rtl/avg_out_stage.sv
module avg_out_stage #(
    parameter int SAMPLE_W  = 14,
    parameter int MAX_SHIFT = 10,
    localparam int ACC_W    = SAMPLE_W + MAX_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       done,
    input  logic signed [ACC_W-1:0]    sum_full,
    input  logic [3:0]                 shift_now,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_data
);
    logic signed [ACC_W-1:0] mean_full;

    always_comb mean_full = sum_full >>> shift_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= done;
            if (done) out_data <= mean_full[SAMPLE_W-1:0];
        end
    end

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));
endmodule

// File: rtl/os_averager.sv
module os_averager
    import os_avg_pkg::*;
#(
    parameter int SAMPLE_W  = 14,
    parameter int MAX_SHIFT = OS_MAX_SHIFT,
    localparam int ACC_W    = SAMPLE_W + MAX_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic [1:0]                 os_mode,
    input  logic [2:0]                 rate_code,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_data
);
    os_cfg_t                 cfg_in;
    logic                    cfg_change, done;
    logic [3:0]              shift_now, shift_q;
    logic signed [ACC_W-1:0] sum_full;

    always_comb begin
        cfg_in.mode = os_mode_e'(os_mode);
        cfg_in.rate = rate_code;
    end

    avg_cfg_track u_cfg (
        .clk(clk), .rst(rst), .cfg_in(cfg_in),
        .cfg_change(cfg_change), .shift_now(shift_now), .shift_q(shift_q)
    );

    avg_accum #(.SAMPLE_W(SAMPLE_W), .MAX_SHIFT(MAX_SHIFT)) u_acc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_change(cfg_change), .shift_now(shift_now), .shift_q(shift_q),
        .done(done), .sum_full(sum_full)
    );

    avg_out_stage #(.SAMPLE_W(SAMPLE_W), .MAX_SHIFT(MAX_SHIFT)) u_out (
        .clk(clk), .rst(rst), .done(done), .sum_full(sum_full),
        .shift_now(shift_now), .out_valid(out_valid), .out_data(out_data)
    );

    assert_no_partial_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$past(cfg_change));
    assert_follows_input_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
endmodule

// File: tb/tb_os_averager.sv
module tb_os_averager;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [13:0] in_sample = '0;
    logic [1:0] os_mode = 2'd0;
    logic [2:0] rate_code = 3'd0;
    logic out_valid;
    logic signed [13:0] out_data;

    int total = 0;
    int bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    os_averager dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .os_mode(os_mode), .rate_code(rate_code),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    function automatic int ref_ratio(input int m, input int r);
        int t[4][8];
        t[0] = '{2, 4, 4, 4, 4, 16, 32, 128};
        t[1] = '{2, 4, 4, 4, 4, 4, 8, 32};
        t[2] = '{2, 4, 8, 16, 32, 128, 256, 1024};
        t[3] = '{2, 2, 2, 2, 2, 2, 4, 16};
        return t[m][r];
    endfunction

    function automatic longint floor_div(input longint s, input longint d);
        longint q;
        q = s / d;
        if (s < 0 && q * d != s) q = q - 1;
        return q;
    endfunction

    // behavioural reference model
    int     m_cfg;
    longint m_sum;
    int     m_cnt;
    logic   e_valid;
    longint e_data;
    bit     model_on = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 0; m_sum = 0; m_cnt = 0; e_valid = 1'b0; e_data = 0;
            model_on = 1'b1;
        end else begin
            e_valid = 1'b0;
            if (int'({os_mode, rate_code}) != m_cfg) begin
                m_cfg = int'({os_mode, rate_code});
                m_sum = 0; m_cnt = 0;
            end
            if (in_valid) begin
                m_sum = m_sum + longint'(in_sample);
                m_cnt = m_cnt + 1;
                if (m_cnt == ref_ratio(int'(os_mode), int'(rate_code))) begin
                    e_valid = 1'b1;
                    e_data = floor_div(m_sum, longint'(m_cnt));
                    m_sum = 0; m_cnt = 0;
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (model_on && !rst) begin
            total++;
            if (out_valid !== e_valid) begin
                bad++;
                $display("FAIL R5 strobe: got %0b expected %0b at %0t", out_valid, e_valid, $time);
            end
            total++;
            if (longint'(out_data) != e_data) begin
                bad++;
                $display("FAIL R4/R9 data: got %0d expected %0d at %0t", out_data, e_data, $time);
            end
        end
    end

    task automatic check(input string req, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic logic signed [13:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:10];
    endfunction

    // feed a fresh run; returns samples fed until strobe and the result
    task automatic run_window(input int m, input int r, input int gap,
                              output int fed, output longint res);
        fed = 0;
        res = 0;
        os_mode = 2'(m);
        rate_code = 3'(r);
        for (int k = 0; k < 2100; k++) begin
            in_valid = 1'b1;
            in_sample = next_rand();
            fed++;
            @(negedge clk);
            if (out_valid) begin
                res = longint'(out_data);
                break;
            end
            if (gap > 0) begin
                in_valid = 1'b0;
                in_sample = next_rand();
                for (int g = 0; g < gap; g++) @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic feed_const(input logic signed [13:0] v, input int n);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b1;
            in_sample = v;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int fed;
        longint res;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", longint'(out_valid), 0);
        check("R1 data in reset", longint'(out_data), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", longint'(out_valid), 0);

        // R2/R3: run length for every mode and rate code
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 8; r++) begin
                run_window(m, r, (r == 1) ? 2 : 0, fed, res);
                check($sformatf("R3 ratio mode=%0d rate=%0d", m, r), fed, ref_ratio(m, r));
                @(negedge clk);
            end
        end

        // R6: idle cycles carry garbage and must not count
        run_window(0, 4, 3, fed, res);
        check("R6 gaps ignored", fed, 4);
        @(negedge clk);

        // R4: negative floor, high-resolution rate 0 (ratio 2)
        os_mode = 2'd2; rate_code = 3'd0;
        in_valid = 1'b1; in_sample = -14'sd3; @(negedge clk);
        in_sample = -14'sd2; @(negedge clk);
        in_valid = 1'b0;
        check("R4 floor of -5/2", longint'(out_data), -3);
        @(negedge clk);
        in_valid = 1'b1; in_sample = 14'sd3; @(negedge clk);
        in_sample = 14'sd2; @(negedge clk);
        in_valid = 1'b0;
        check("R4 floor of 5/2", longint'(out_data), 2);
        @(negedge clk);
        check("R5 strobe one cycle", longint'(out_valid), 0);
        check("R9 hold", longint'(out_data), 2);

        // R7: partial run discarded on code change
        os_mode = 2'd2; rate_code = 3'd5;
        feed_const(14'sd4000, 50);
        check("R7 no output from partial", longint'(out_valid), 0);
        os_mode = 2'd2; rate_code = 3'd0;
        in_valid = 1'b1; in_sample = 14'sd4; @(negedge clk);
        check("R7 no strobe at change", longint'(out_valid), 0);
        in_sample = 14'sd6; @(negedge clk);
        in_valid = 1'b0;
        check("R7 fresh run mean", longint'(out_data), 5);
        check("R7 fresh run strobe", longint'(out_valid), 1);
        @(negedge clk);

        // R8: full-scale runs of 1024
        os_mode = 2'd2; rate_code = 3'd7;
        @(negedge clk);
        feed_const(-14'sd8192, 1024);
        check("R8 negative full scale", longint'(out_data), -8192);
        @(negedge clk);
        feed_const(14'sd8191, 1024);
        check("R8 positive full scale", longint'(out_data), 8191);
        @(negedge clk);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule